// File: doc/BRIEF.md
# Pass-Through Mode Entry Sequencer

This block decides whether a chained single-wire interface unit passes host port signals straight through or runs in normal mode. It also decides whether the unit is the last one in the chain. After power-up the unit passes traffic through: the paths for the two status lines and the enable link are all closed, and single-wire traffic is not possible. The host leaves this mode by issuing four overdrive-toggle commands in a row. It must then hold enable-in high (inactive) for a quiet interval of `QUIET_MS` millisecond ticks. Four toggles in a row issued in normal mode return the unit to pass-through at once, with no quiet wait. A command decoder supplies single-cycle command strobes. A millisecond tick provides the time base.

While the unit is in pass-through, enable-out may stay low for longer than `CUT_MS` ticks. The block then opens the path from enable-in to enable-out, so the host can always reach this unit to take it out of pass-through. During each reset slot the block watches the busy indication returned by the downstream unit. If that indication never appears before the slot ends, the block marks this unit as the last one in the chain.

Top module: `chain_mode_seq`

## Requirements
- R1: After reset, `mode_normal` is 0 (pass-through), `gate_en` is 3'b111 (bit 0 = enable-in to enable-out link, bit 1 = status line 1 path, bit 2 = status line 2 path) and `last_unit` is 0.
- R2: Once four toggle strobes have been received with no other command between them, `QUIET_MS` ticks with `en_in` high switch the block to normal mode. The switch appears on `mode_normal` at the clock edge that samples the last tick. From then on `gate_en` is 3'b000.
- R3: Fewer than four toggle strobes, however long `en_in` then stays high, leave the mode unchanged.
- R4: A `cmd_other` strobe clears the toggle count in either mode, so four fresh toggles are needed afterwards.
- R5: Any cycle with `en_in` low during the quiet wait restarts it. The switch then needs `QUIET_MS` further ticks with `en_in` high.
- R6: In normal mode, the fourth consecutive toggle strobe switches the block to pass-through at the next clock edge, with no wait. `gate_en` returns to 3'b111, with the link path closed again.
- R7: In pass-through, `en_out` low through `CUT_MS`+1 consecutive ticks clears `gate_en[0]` at the edge sampling the last of those ticks. `gate_en[2:1]` stay 1. A cycle with `en_out` high restarts the count, and the cut lasts until the next mode change.
- R8: When a reset slot ends (`rst_end`), `last_unit` becomes 1 if `dn_busy` was never high since the slot began (`rst_start`), including the end cycle. Otherwise it becomes 0. Every reset slot re-evaluates it.
- R9: Toggle strobes beyond the fourth in pass-through keep the count at four, so the block still arms and switches after the quiet wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| cmd_toggle | input | 1 | Strobe: overdrive-toggle command decoded |
| cmd_other | input | 1 | Strobe: any other slot command decoded |
| en_in | input | 1 | Enable-in level, high = inactive |
| en_out | input | 1 | Enable-out line level |
| rst_start | input | 1 | Strobe: a reset slot begins |
| rst_end | input | 1 | Strobe: the reset slot ends |
| dn_busy | input | 1 | Busy indication seen from the downstream unit |
| mode_normal | output | 1 | 1 = normal mode, 0 = pass-through |
| gate_en | output | 3 | Pass-through path enables (see R1) |
| last_unit | output | 1 | 1 = this unit is the last in the chain |

## Verification
Every result is one register stage from its cause. A mode change, a link cut or a new last-unit value appears at the edge that samples the deciding strobe or tick, and it is visible at the following falling edge. The bench drives inputs just after a falling edge. A behavioural model advances on the same rising edge, and the bench compares all outputs with it at every falling edge. For quiet and cut windows, directed checks are placed one tick before the threshold and again at the threshold. The bench holds each tick for a single cycle followed by two idle cycles, so a tick count maps directly to a known edge.

// File: rtl/chain_mode_pkg.sv
// Package: shared types and gate bit positions for the pass-through sequencer.
// Assumes: gate bit order is decoded by the switch driver outside this block.
package chain_mode_pkg;
    typedef enum logic {
        MODE_PASS   = 1'b0,
        MODE_NORMAL = 1'b1
    } mode_e;

    localparam int GATE_LINK = 0;   // enable-in to enable-out link
    localparam int GATE_ST1  = 1;   // status line 1 path
    localparam int GATE_ST2  = 2;   // status line 2 path
    localparam int GATE_W    = 3;
endpackage

// File: rtl/toggle_counter.sv
// Module: counts consecutive toggle strobes, saturating at NEEDED.
// Assumes: cmd strobes last one cycle; clear has priority over counting.
module toggle_counter #(
    parameter int NEEDED = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          toggle,
    input  logic                          other,
    input  logic                          clear,
    output logic [$clog2(NEEDED+1)-1:0]   count,
    output logic                          full
);
    localparam int W = $clog2(NEEDED + 1);

    assign full = (count == W'(NEEDED));

    // Purpose: advance, clear or hold the consecutive-toggle count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear || other) begin
            count <= '0;
        end else if (toggle && !full) begin
            count <= count + 1'b1;
        end
    end

    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= W'(NEEDED));

    a_r4_other_clears: assert property (@(posedge clk) disable iff (!rst_n)
        other |=> (count == '0));
endmodule

// File: rtl/ms_window.sv
// Module: counts millisecond ticks while run is high; hit pulses on the tick
// that completes LIMIT ticks. Dropping run restarts the window.
// Assumes: LIMIT >= 1; tick is a one-cycle pulse.
module ms_window #(
    parameter int LIMIT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic hit
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt;

    assign hit = run && tick && (cnt == W'(LIMIT - 1));

    // Purpose: accumulate ticks while run holds, restart when it drops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (tick && cnt != W'(LIMIT)) begin
            cnt <= cnt + 1'b1;
        end
    end

    a_r5_restart_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));
endmodule

// File: rtl/last_unit_det.sv
// Module: decides from downstream busy activity during a reset slot whether
// this unit ends the chain.
// Assumes: rst_start precedes rst_end; busy in the end cycle still counts.
module last_unit_det (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_start,
    input  logic rst_end,
    input  logic dn_busy,
    output logic last_unit
);
    logic in_slot;
    logic seen;

    // Purpose: track the slot window and any busy seen within it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_slot <= 1'b0;
            seen    <= 1'b0;
        end else if (rst_start) begin
            in_slot <= 1'b1;
            seen    <= 1'b0;
        end else if (in_slot) begin
            if (dn_busy) seen <= 1'b1;
            if (rst_end) in_slot <= 1'b0;
        end
    end

    // Purpose: re-evaluate the last-unit flag when a slot ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_unit <= 1'b0;
        end else if (in_slot && rst_end && !rst_start) begin
            last_unit <= !(seen || dn_busy);
        end
    end

    a_r8_changes_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(last_unit) |-> $past(rst_end));
endmodule

// File: rtl/chain_mode_seq.sv
// Module: top of the pass-through mode sequencer. Holds the mode flag, the
// link-cut state and the gate enables; instantiates the toggle counter, the
// quiet window, the enable-out low window and the last-unit detector.
// Assumes: command strobes are mutually exclusive one-cycle pulses.
module chain_mode_seq
    import chain_mode_pkg::*;
#(
    parameter int TOGGLES  = 4,
    parameter int QUIET_MS = 10,
    parameter int CUT_MS   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ms_tick,
    input  logic              cmd_toggle,
    input  logic              cmd_other,
    input  logic              en_in,
    input  logic              en_out,
    input  logic              rst_start,
    input  logic              rst_end,
    input  logic              dn_busy,
    output logic              mode_normal,
    output logic [GATE_W-1:0] gate_en,
    output logic              last_unit
);
    localparam int CW = $clog2(TOGGLES + 1);

    mode_e          mode;
    logic           link_cut;
    logic [CW-1:0]  tog_cnt;
    logic           tog_full;
    logic           quiet_run, quiet_hit;
    logic           cut_run, cut_hit;
    logic           to_pass, to_normal, mode_chg;

    // Purpose: decide mode transitions from the count and the quiet window.
    always_comb begin
        to_pass   = (mode == MODE_NORMAL) && cmd_toggle && !cmd_other
                    && (tog_cnt == CW'(TOGGLES - 1));
        to_normal = quiet_hit;
        mode_chg  = to_pass || to_normal;
        quiet_run = (mode == MODE_PASS) && tog_full && en_in;
        cut_run   = (mode == MODE_PASS) && !en_out && !link_cut;
    end

    toggle_counter #(.NEEDED(TOGGLES)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .toggle (cmd_toggle),
        .other  (cmd_other),
        .clear  (mode_chg),
        .count  (tog_cnt),
        .full   (tog_full)
    );

    ms_window #(.LIMIT(QUIET_MS)) u_quiet (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (quiet_run),
        .tick  (ms_tick),
        .hit   (quiet_hit)
    );

    ms_window #(.LIMIT(CUT_MS + 1)) u_cut (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (cut_run),
        .tick  (ms_tick),
        .hit   (cut_hit)
    );

    last_unit_det u_last (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_start (rst_start),
        .rst_end   (rst_end),
        .dn_busy   (dn_busy),
        .last_unit (last_unit)
    );

    // Purpose: hold the operating mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= MODE_PASS;
        end else if (to_pass) begin
            mode <= MODE_PASS;
        end else if (to_normal) begin
            mode <= MODE_NORMAL;
        end
    end

    // Purpose: open the enable link after a long enable-out low; reclose on mode change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_cut <= 1'b0;
        end else if (mode_chg) begin
            link_cut <= 1'b0;
        end else if (cut_hit) begin
            link_cut <= 1'b1;
        end
    end

    // Purpose: drive the mode flag and the gate enables.
    always_comb begin
        mode_normal = (mode == MODE_NORMAL);
        gate_en     = '0;
        if (mode == MODE_PASS) begin
            gate_en[GATE_LINK] = !link_cut;
            gate_en[GATE_ST1]  = 1'b1;
            gate_en[GATE_ST2]  = 1'b1;
        end
    end

    a_r2_enter_needs_full_count: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_normal) |-> ($past(tog_cnt) == CW'(TOGGLES)) && $past(en_in) && $past(ms_tick));

    a_r6_leave_on_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mode_normal) |-> $past(cmd_toggle));

    a_r7_cut_after_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_cut) |-> !$past(en_out) && $past(ms_tick));

    a_r7_cut_only_pass: assert property (@(posedge clk) disable iff (!rst_n)
        link_cut |-> !mode_normal);
endmodule

// File: tb/chain_mode_seq_tb.sv
`timescale 1ns/1ps
module chain_mode_seq_tb;
    localparam int TOG = 4;
    localparam int QMS = 10;
    localparam int CMS = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ms_tick = 0, cmd_toggle = 0, cmd_other = 0;
    logic en_in = 1, en_out = 1, rst_start = 0, rst_end = 0, dn_busy = 0;
    logic mode_normal, last_unit;
    logic [2:0] gate_en;

    int vectors = 0;
    int fails = 0;
    string cur_req = "R1";

    // behavioural reference state
    int  m_cnt = 0, m_q = 0, m_e = 0;
    bit  m_norm = 0, m_cut = 0, m_last = 0, m_in = 0, m_seen = 0;

    always #2.5 clk = ~clk;

    chain_mode_seq #(.TOGGLES(TOG), .QUIET_MS(QMS), .CUT_MS(CMS)) u_dut (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .cmd_toggle(cmd_toggle),
        .cmd_other(cmd_other), .en_in(en_in), .en_out(en_out),
        .rst_start(rst_start), .rst_end(rst_end), .dn_busy(dn_busy),
        .mode_normal(mode_normal), .gate_en(gate_en), .last_unit(last_unit)
    );

    // reference model advanced on each rising edge from the requirements
    always @(posedge clk) begin
        bit flip_pass, q_hit, e_hit, q_run, e_run;
        if (!rst_n) begin
            m_cnt = 0; m_q = 0; m_e = 0; m_norm = 0; m_cut = 0;
            m_last = 0; m_in = 0; m_seen = 0;
        end else begin
            flip_pass = m_norm && cmd_toggle && !cmd_other && (m_cnt == TOG - 1);
            q_run = !m_norm && (m_cnt == TOG) && en_in;
            e_run = !m_norm && !en_out && !m_cut;
            q_hit = q_run && ms_tick && (m_q == QMS - 1);
            e_hit = e_run && ms_tick && (m_e == CMS);
            m_q = !q_run ? 0 : (ms_tick && m_q < QMS) ? m_q + 1 : m_q;
            m_e = !e_run ? 0 : (ms_tick && m_e < CMS + 1) ? m_e + 1 : m_e;
            if (flip_pass || q_hit || cmd_other) m_cnt = 0;
            else if (cmd_toggle && m_cnt < TOG) m_cnt = m_cnt + 1;
            if (flip_pass) m_norm = 0;
            else if (q_hit) m_norm = 1;
            if (flip_pass || q_hit) m_cut = 0;
            else if (e_hit) m_cut = 1;
            if (rst_start) begin m_in = 1; m_seen = 0; end
            else if (m_in) begin
                if (rst_end) begin m_last = !(m_seen || dn_busy); m_in = 0; end
                else if (dn_busy) m_seen = 1;
            end
        end
    end

    task automatic check(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // one cycle: wait for falling edge, compare outputs with the model
    task automatic cyc();
        @(negedge clk);
        if (rst_n) begin
            check({cur_req, " mode"}, mode_normal, m_norm);
            check({cur_req, " gate"}, gate_en, m_norm ? 0 : {2'b11, !m_cut});
            check({cur_req, " last"}, last_unit, m_last);
        end
    endtask

    task automatic toggles(int n);
        for (int i = 0; i < n; i++) begin
            cmd_toggle = 1; cyc(); cmd_toggle = 0; cyc();
        end
    endtask

    task automatic other();
        cmd_other = 1; cyc(); cmd_other = 0; cyc();
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            ms_tick = 1; cyc(); ms_tick = 0; cyc(); cyc();
        end
    endtask

    task automatic rslot(bit busy_mid, bit busy_end);
        rst_start = 1; cyc(); rst_start = 0;
        cyc();
        dn_busy = busy_mid; cyc(); dn_busy = 0; cyc();
        rst_end = 1; dn_busy = busy_end; cyc(); rst_end = 0; dn_busy = 0; cyc();
    endtask

    initial begin
        #500000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        cur_req = "R1";
        check("R1 mode", mode_normal, 0);
        check("R1 gate", gate_en, 3'b111);
        check("R1 last", last_unit, 0);

        cur_req = "R3";
        toggles(3); ticks(QMS + 2);
        check("R3 three toggles no switch", mode_normal, 0);

        cur_req = "R4";
        toggles(3); other(); toggles(1); ticks(QMS + 2);
        check("R4 other clears count", mode_normal, 0);
        other();

        cur_req = "R5";
        toggles(4); ticks(5);
        en_in = 0; cyc(); en_in = 1; cyc();
        ticks(QMS - 1);
        check("R5 wait restarted", mode_normal, 0);
        cur_req = "R2";
        ticks(1);
        check("R2 normal after quiet", mode_normal, 1);
        check("R2 gates open", gate_en, 3'b000);

        cur_req = "R4";
        toggles(3); other(); toggles(3);
        check("R4 normal count cleared", mode_normal, 1);
        cur_req = "R6";
        toggles(1);
        check("R6 back to pass-through", mode_normal, 0);
        check("R6 gates closed", gate_en, 3'b111);

        cur_req = "R9";
        toggles(6); ticks(QMS);
        check("R9 saturated count arms", mode_normal, 1);
        cur_req = "R6";
        toggles(4);
        check("R6 pass again", mode_normal, 0);

        cur_req = "R7";
        en_out = 0; ticks(CMS);
        en_out = 1; cyc(); en_out = 0;
        ticks(CMS);
        check("R7 not yet cut", gate_en, 3'b111);
        ticks(1);
        check("R7 link cut", gate_en, 3'b110);
        en_out = 1; ticks(2);
        check("R7 cut holds", gate_en, 3'b110);
        toggles(4); ticks(QMS);
        check("R7 normal clears", gate_en, 3'b000);
        cur_req = "R6";
        toggles(4);
        check("R6 link reclosed", gate_en, 3'b111);

        cur_req = "R8";
        rslot(0, 0);
        check("R8 no busy last", last_unit, 1);
        rslot(1, 0);
        check("R8 busy mid not last", last_unit, 0);
        rslot(0, 0);
        check("R8 re-evaluated", last_unit, 1);
        rslot(0, 1);
        check("R8 busy at end", last_unit, 0);

        cyc(); cyc();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule